// File: doc/BRIEF.md
# Sync-Hunting Packet Frame Receiver

This block sits behind a bit-level deserializer that delivers one byte at a time with a one-cycle valid strobe. While idle it hunts for the start marker 0xC3 and throws away every other byte, including the self-synchronizing run that precedes a packet and the zero byte that follows one. Once the marker is seen it captures seven header bytes and removes their top bit. It then rebuilds the payload from its transmitted form. On the line every byte carries bit 7 set, so the true top bits of the payload travel in separate MSB bytes, one ahead of the short leading section and one ahead of each seven-byte group. The rebuilt bytes go into a local buffer that a consumer reads through a plain address port.

After the payload come two checksum bytes and the end marker 0xC8. A clean frame ends with a one-cycle valid pulse. At that point the header outputs, the payload length and the buffer hold the packet. Any fault ends the packet with a one-cycle error pulse, and the receiver goes back to hunting. Faults are: a bad checksum, a wrong end byte, a byte without bit 7, a header that asks for too much payload, or a silence on the line longer than a set multiple of the nominal byte spacing.

Top module: `frame_rx`

## Requirements
- R1: While hunting, every byte other than 0xC3 is discarded, whether it is a sync byte (0xFF, 0x3F, 0xCF, 0xF3, 0xFC), the 0x00 clear byte or any other value. Reception starts only on 0xC3.
- R2: The seven bytes after the marker are, in order: destination, source, type, auxiliary type, status, odd count, group count. Each is stored with bit 7 cleared. The first five are presented on hdrDest, hdrSrc, hdrType, hdrAux and hdrStat and are valid during the pktValid pulse.
- R3: Let O be the odd count and G the group count. payLen is O + 7*G. If O > 0, one MSB byte and then O data bytes follow the header. Next come G sections, each made of one MSB byte followed by seven data bytes. The k-th data byte of a section (k = 0 first) is rebuilt as its own bits 6..0 with bit 7 taken from bit (6 - k) of that section's MSB byte. Rebuilt bytes are stored at buffer addresses 0, 1, 2, … in arrival order and are read on rdData at rdAddr.
- R4: The checksum is the XOR of the seven header values (bit 7 cleared) and all rebuilt payload bytes. With c1 and c2 the two bytes after the payload, the received value is (c1 AND 0x55) OR ((c2 AND 0x55) << 1). A mismatch gives pktError.
- R5: The byte after c2 must be 0xC8. Any other value gives pktError.
- R6: After the marker, a byte with bit 7 clear gives pktError in the cycle after that byte, and hunting resumes at once.
- R7: When the group count byte arrives, the packet is aborted with pktError if O > 6 or O + 7*G > MAX_PAYLOAD. A length equal to MAX_PAYLOAD is accepted.
- R8: Inside a packet, BYTE_CYCLES*GAP_MULT consecutive cycles without a byte give pktError and a return to hunting. A byte that arrives in the cycle the limit would be reached keeps the packet alive.
- R9: pktValid and pktError are registered one-cycle pulses, issued the cycle after the deciding byte or idle cycle. They are never high together, and each packet produces at most one of them.
- R10: After reset, pktValid, pktError, the header outputs and payLen are all zero, and the receiver is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One-cycle strobe: byteData holds a received byte |
| byteData | input | 8 | Received byte |
| rdAddr | input | $clog2(MAX_PAYLOAD) | Payload buffer read address |
| hdrDest | output | 7 | Destination field |
| hdrSrc | output | 7 | Source field |
| hdrType | output | 7 | Type field |
| hdrAux | output | 7 | Auxiliary type field |
| hdrStat | output | 7 | Status field |
| payLen | output | $clog2(MAX_PAYLOAD+1) | Rebuilt payload length in bytes |
| rdData | output | 8 | Payload byte at rdAddr (combinational) |
| pktValid | output | 1 | Pulse: clean frame received |
| pktError | output | 1 | Pulse: frame aborted or rejected |

## Verification
The gap timer and byte arrival can fall in the same cycle. A byte arriving in the very cycle the idle count would reach its limit must win, and the packet must go on. The bench spaces every byte of one frame exactly one idle cycle short of the limit and expects a valid pulse. It then holds a single gap of exactly the limit in the middle of another frame and expects an error pulse on that idle cycle and nothing more. The behavioural model in the bench resolves the same cycle by giving the byte precedence, and it is compared with the design on every clock.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  localparam logic [7:0] START_MARK  = 8'hC3;
  localparam logic [7:0] END_MARK    = 8'hC8;
  localparam int         HDR_BYTES   = 7;
  localparam int         GROUP_BYTES = 7;

  typedef enum logic [3:0] {
    ST_HUNT, ST_HDR, ST_ODDMSB, ST_ODDDAT, ST_GRPMSB,
    ST_GRPDAT, ST_CHK1, ST_CHK2, ST_END
  } rxState_e;

  // strobes from control to datapath, valid for one byte
  typedef struct packed {
    logic       clearSum;
    logic       hdrWe;
    logic [2:0] hdrIdx;
    logic       msbWe;
    logic       dataWe;
    logic [2:0] dataBit;
    logic       chk1We;
    logic       chk2We;
  } rxStrobe_t;

endpackage

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
#(
  parameter int MAX_PAYLOAD = 32,
  parameter int GAP_LIMIT   = 25600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic [6:0] oddCnt,
  input  logic       sumOk,
  output rxStrobe_t  strb,
  output logic       pktValid,
  output logic       pktError
);

  localparam int GW = $clog2(GAP_LIMIT + 1);

  rxState_e      state, stateNx;
  logic [2:0]    idx, idxNx;
  logic [6:0]    grpLeft, grpLeftNx;
  logic [GW-1:0] gapCnt;
  logic          validNx, errNx;
  logic          gapExpire;
  logic [9:0]    lenCalc;

  assign lenCalc   = 10'(oddCnt) + 10'(byteData[6:0]) * 10'd7;
  assign gapExpire = (state != ST_HUNT) && !byteValid &&
                     (gapCnt == GW'(GAP_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN || state == ST_HUNT || byteValid || gapExpire) gapCnt <= '0;
    else gapCnt <= gapCnt + 1'b1;
  end

  always_comb begin
    stateNx   = state;
    idxNx     = idx;
    grpLeftNx = grpLeft;
    strb      = '0;
    validNx   = 1'b0;
    errNx     = 1'b0;
    if (state == ST_HUNT) begin
      if (byteValid && byteData == START_MARK) begin
        stateNx       = ST_HDR;
        idxNx         = '0;
        strb.clearSum = 1'b1;
      end
    end else if (gapExpire) begin
      errNx   = 1'b1;
      stateNx = ST_HUNT;
    end else if (byteValid) begin
      if (!byteData[7]) begin
        errNx   = 1'b1;
        stateNx = ST_HUNT;
      end else begin
        unique case (state)
          ST_HDR: begin
            strb.hdrWe  = 1'b1;
            strb.hdrIdx = idx;
            idxNx       = idx + 1'b1;
            if (idx == 3'(HDR_BYTES - 1)) begin
              idxNx     = '0;
              grpLeftNx = byteData[6:0];
              if (oddCnt > 7'(GROUP_BYTES - 1) || lenCalc > 10'(MAX_PAYLOAD)) begin
                errNx   = 1'b1;
                stateNx = ST_HUNT;
              end else if (oddCnt != 7'd0)        stateNx = ST_ODDMSB;
              else if (byteData[6:0] != 7'd0)     stateNx = ST_GRPMSB;
              else                                stateNx = ST_CHK1;
            end
          end
          ST_ODDMSB: begin
            strb.msbWe = 1'b1;
            idxNx      = '0;
            stateNx    = ST_ODDDAT;
          end
          ST_ODDDAT: begin
            strb.dataWe  = 1'b1;
            strb.dataBit = 3'd6 - idx;
            idxNx        = idx + 1'b1;
            if ({4'b0, idx} == oddCnt - 7'd1)
              stateNx = (grpLeft != 7'd0) ? ST_GRPMSB : ST_CHK1;
          end
          ST_GRPMSB: begin
            strb.msbWe = 1'b1;
            idxNx      = '0;
            stateNx    = ST_GRPDAT;
          end
          ST_GRPDAT: begin
            strb.dataWe  = 1'b1;
            strb.dataBit = 3'd6 - idx;
            idxNx        = idx + 1'b1;
            if (idx == 3'(GROUP_BYTES - 1)) begin
              grpLeftNx = grpLeft - 1'b1;
              stateNx   = (grpLeft == 7'd1) ? ST_CHK1 : ST_GRPMSB;
            end
          end
          ST_CHK1: begin
            strb.chk1We = 1'b1;
            stateNx     = ST_CHK2;
          end
          ST_CHK2: begin
            strb.chk2We = 1'b1;
            stateNx     = ST_END;
          end
          ST_END: begin
            if (byteData == END_MARK && sumOk) validNx = 1'b1;
            else errNx = 1'b1;
            stateNx = ST_HUNT;
          end
          default: stateNx = ST_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      idx      <= '0;
      grpLeft  <= '0;
      pktValid <= 1'b0;
      pktError <= 1'b0;
    end else begin
      state    <= stateNx;
      idx      <= idxNx;
      grpLeft  <= grpLeftNx;
      pktValid <= validNx;
      pktError <= errNx;
    end
  end

  // R9: outcome pulses exclusive and single-cycle
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(pktValid && pktError));
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid);
  // R1: any outcome leaves the receiver hunting
  assert_hunt_after_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid || pktError) |-> state == ST_HUNT);
  // R6: missing top bit inside a packet aborts next cycle
  assert_nobit7_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_HUNT && byteValid && !byteData[7]) |=> pktError);
  // R8: idle counter never passes its limit
  assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt < GW'(GAP_LIMIT));

endmodule

// File: rtl/frame_rx_dp.sv
module frame_rx_dp
  import frame_rx_pkg::*;
#(
  parameter  int MAX_PAYLOAD = 32,
  localparam int AW = $clog2(MAX_PAYLOAD),
  localparam int LW = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxStrobe_t     strb,
  input  logic [7:0]    byteData,
  input  logic [AW-1:0] rdAddr,
  output logic [6:0]    hdrDest,
  output logic [6:0]    hdrSrc,
  output logic [6:0]    hdrType,
  output logic [6:0]    hdrAux,
  output logic [6:0]    hdrStat,
  output logic [6:0]    oddCnt,
  output logic [LW-1:0] payLen,
  output logic [7:0]    rdData,
  output logic          sumOk
);

  logic [6:0]    hdrReg [HDR_BYTES];
  logic [6:0]    msbReg;
  logic [7:0]    acc, chk1Reg, chk2Reg;
  logic [LW-1:0] wrAddr;
  logic [7:0]    pktMem [MAX_PAYLOAD];
  logic [7:0]    decoded;
  logic [9:0]    lenFull;

  assign decoded = {msbReg[strb.dataBit], byteData[6:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HDR_BYTES; i++) hdrReg[i] <= '0;
      msbReg  <= '0;
      acc     <= '0;
      chk1Reg <= '0;
      chk2Reg <= '0;
      wrAddr  <= '0;
    end else begin
      if (strb.clearSum) begin
        acc    <= '0;
        wrAddr <= '0;
      end
      if (strb.hdrWe) begin
        hdrReg[strb.hdrIdx] <= byteData[6:0];
        acc <= acc ^ {1'b0, byteData[6:0]};
      end
      if (strb.msbWe) msbReg <= byteData[6:0];
      if (strb.dataWe) begin
        acc    <= acc ^ decoded;
        wrAddr <= wrAddr + 1'b1;
      end
      if (strb.chk1We) chk1Reg <= byteData;
      if (strb.chk2We) chk2Reg <= byteData;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.dataWe && wrAddr < LW'(MAX_PAYLOAD))
      pktMem[wrAddr[AW-1:0]] <= decoded;
  end

  assign sumOk   = acc == ((chk1Reg & 8'h55) | ((chk2Reg & 8'h55) << 1));
  assign hdrDest = hdrReg[0];
  assign hdrSrc  = hdrReg[1];
  assign hdrType = hdrReg[2];
  assign hdrAux  = hdrReg[3];
  assign hdrStat = hdrReg[4];
  assign oddCnt  = hdrReg[5];
  assign lenFull = 10'(hdrReg[5]) + 10'(hdrReg[6]) * 10'd7;
  assign payLen  = lenFull[LW-1:0];
  assign rdData  = pktMem[rdAddr];

  // R7: control never writes past the buffer
  assert_addr_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWe |-> wrAddr < LW'(MAX_PAYLOAD));
  // R4: a start marker restarts checksum and fill pointer
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearSum |=> (acc == 8'h00 && wrAddr == '0));

endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_rx_pkg::*;
#(
  parameter  int MAX_PAYLOAD = 32,
  parameter  int BYTE_CYCLES = 6400,
  parameter  int GAP_MULT    = 4,
  localparam int AW = $clog2(MAX_PAYLOAD),
  localparam int LW = $clog2(MAX_PAYLOAD + 1),
  localparam int GAP_LIMIT = BYTE_CYCLES * GAP_MULT
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          byteValid,
  input  logic [7:0]    byteData,
  input  logic [AW-1:0] rdAddr,
  output logic [6:0]    hdrDest,
  output logic [6:0]    hdrSrc,
  output logic [6:0]    hdrType,
  output logic [6:0]    hdrAux,
  output logic [6:0]    hdrStat,
  output logic [LW-1:0] payLen,
  output logic [7:0]    rdData,
  output logic          pktValid,
  output logic          pktError
);

  rxStrobe_t  strb;
  logic [6:0] oddCnt;
  logic       sumOk;

  frame_rx_ctrl #(.MAX_PAYLOAD(MAX_PAYLOAD), .GAP_LIMIT(GAP_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .oddCnt(oddCnt), .sumOk(sumOk), .strb(strb),
    .pktValid(pktValid), .pktError(pktError)
  );

  frame_rx_dp #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData), .rdAddr(rdAddr),
    .hdrDest(hdrDest), .hdrSrc(hdrSrc), .hdrType(hdrType), .hdrAux(hdrAux),
    .hdrStat(hdrStat), .oddCnt(oddCnt), .payLen(payLen), .rdData(rdData),
    .sumOk(sumOk)
  );

endmodule

// File: tb/frame_rx_tb.sv
`timescale 1ns/1ps
module frame_rx_tb;

  localparam int MAXP = 32;
  localparam int BC   = 4;
  localparam int GM   = 3;
  localparam int LIM  = BC * GM;

  logic       clk = 1'b0, rstN = 1'b0, byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic [4:0] rdAddr = '0;
  logic [6:0] hdrDest, hdrSrc, hdrType, hdrAux, hdrStat;
  logic [5:0] payLen;
  logic [7:0] rdData;
  logic       pktValid, pktError;

  frame_rx #(.MAX_PAYLOAD(MAXP), .BYTE_CYCLES(BC), .GAP_MULT(GM)) u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .rdAddr(rdAddr), .hdrDest(hdrDest), .hdrSrc(hdrSrc), .hdrType(hdrType),
    .hdrAux(hdrAux), .hdrStat(hdrStat), .payLen(payLen), .rdData(rdData),
    .pktValid(pktValid), .pktError(pktError)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0, errors = 0;
  string curReq = "R10";
  bit    done = 1'b0;
  int    gotValid = 0, gotErr = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit           mIn = 0, expValid = 0, expErr = 0;
  int           mGap = 0, mTotal = 0, expLen = 0;
  byte unsigned raw[$];
  byte unsigned expPay[$];
  byte unsigned expHdr[5];
  int           mO, mG, mIx, mP;
  byte unsigned mSum, mMsb, mC1, mC2;
  byte unsigned mPay[$];

  always @(posedge clk) begin
    expValid = 0;
    expErr   = 0;
    if (!rstN) begin
      mIn = 0; mGap = 0;
    end else if (mIn) begin
      if (byteValid) begin
        mGap = 0;
        if (!byteData[7]) begin
          mIn = 0; expErr = 1;
        end else begin
          raw.push_back(byteData);
          mP = raw.size() - 1;
          if (mP == 6) begin
            mO = raw[5] & 8'h7f;
            mG = raw[6] & 8'h7f;
            if (mO > 6 || mO + 7 * mG > MAXP) begin
              mIn = 0; expErr = 1;
            end else mTotal = 7 + ((mO > 0) ? mO + 1 : 0) + 8 * mG + 3;
          end else if (mP > 6 && mP == mTotal - 1) begin
            mPay.delete();
            mSum = 0;
            for (int i = 0; i < 7; i++) mSum ^= (raw[i] & 8'h7f);
            mIx = 7;
            if (mO > 0) begin
              mMsb = raw[mIx];
              for (int k = 0; k < mO; k++) mPay.push_back({mMsb[6-k], raw[mIx+1+k][6:0]});
              mIx += mO + 1;
            end
            for (int g = 0; g < mG; g++) begin
              mMsb = raw[mIx];
              for (int k = 0; k < 7; k++) mPay.push_back({mMsb[6-k], raw[mIx+1+k][6:0]});
              mIx += 8;
            end
            foreach (mPay[i]) mSum ^= mPay[i];
            mC1 = raw[mIx]; mC2 = raw[mIx+1];
            mIn = 0;
            if (raw[mIx+2] == 8'hC8 && mSum == ((mC1 & 8'h55) | ((mC2 & 8'h55) << 1))) begin
              expValid = 1;
              for (int i = 0; i < 5; i++) expHdr[i] = raw[i] & 8'h7f;
              expLen = mO + 7 * mG;
              expPay = mPay;
            end else expErr = 1;
          end
        end
      end else begin
        mGap++;
        if (mGap == LIM) begin mIn = 0; expErr = 1; end
      end
    end else if (byteValid && byteData == 8'hC3) begin
      mIn = 1; mGap = 0; raw.delete(); mTotal = 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(pktValid === expValid, "pktValid (R9)", pktValid, expValid);
      check(pktError === expErr, "pktError (R9)", pktError, expErr);
      if (pktValid) gotValid++;
      if (pktError) gotErr++;
      if (expValid) begin
        check(hdrDest == expHdr[0], "hdrDest R2", hdrDest, expHdr[0]);
        check(hdrSrc  == expHdr[1], "hdrSrc R2",  hdrSrc,  expHdr[1]);
        check(hdrType == expHdr[2], "hdrType R2", hdrType, expHdr[2]);
        check(hdrAux  == expHdr[3], "hdrAux R2",  hdrAux,  expHdr[3]);
        check(hdrStat == expHdr[4], "hdrStat R2", hdrStat, expHdr[4]);
        check(payLen  == expLen,    "payLen R3",  payLen,  expLen);
      end
    end
  end

  // ---------------- stimulus ----------------
  byte unsigned tx[$];

  task automatic buildFrame(input byte unsigned d, s, t, a, st,
                            input byte unsigned pay[$], input int oddForce, input int corrupt);
    int o, g, n;
    byte unsigned chk, m, hb[7], c1, c2;
    n = pay.size(); o = n % 7; g = n / 7;
    tx.push_back(8'h00); tx.push_back(8'h55); tx.push_back(8'hC8);
    tx.push_back(8'hFF); tx.push_back(8'h3F); tx.push_back(8'hCF);
    tx.push_back(8'hF3); tx.push_back(8'hFC); tx.push_back(8'hFF);
    tx.push_back(8'hC3);
    hb[0] = d; hb[1] = s; hb[2] = t; hb[3] = a; hb[4] = st;
    hb[5] = (oddForce >= 0) ? oddForce[6:0] : o[6:0];
    hb[6] = g[6:0];
    chk = 0;
    for (int i = 0; i < 7; i++) begin
      tx.push_back(hb[i] | 8'h80);
      chk ^= (hb[i] & 8'h7f);
    end
    foreach (pay[i]) chk ^= pay[i];
    if (o > 0) begin
      m = 0;
      for (int k = 0; k < o; k++) m[6-k] = pay[k][7];
      tx.push_back(m | 8'h80);
      for (int k = 0; k < o; k++) tx.push_back(pay[k] | 8'h80);
    end
    for (int gi = 0; gi < g; gi++) begin
      m = 0;
      for (int k = 0; k < 7; k++) m[6-k] = pay[o + 7*gi + k][7];
      tx.push_back(m | 8'h80);
      for (int k = 0; k < 7; k++) tx.push_back(pay[o + 7*gi + k] | 8'h80);
    end
    c1 = chk | 8'hAA;
    c2 = (chk >> 1) | 8'hAA;
    if (corrupt == 1) c1 ^= 8'h01;
    tx.push_back(c1); tx.push_back(c2);
    tx.push_back((corrupt == 2) ? 8'hC9 : 8'hC8);
    tx.push_back(8'h00);
    if (corrupt == 3) tx[18] = tx[18] & 8'h7f;
  endtask

  task automatic sendAll(input int idle, input int stallAt, input int stallLen);
    foreach (tx[i]) begin
      byteValid = 1'b1;
      byteData  = tx[i];
      @(negedge clk);
      byteValid = 1'b0;
      repeat ((i == stallAt) ? stallLen : idle) @(negedge clk);
    end
    tx.delete();
    repeat (LIM + 4) @(negedge clk);
  endtask

  task automatic runFrame(input string req, input byte unsigned pay[$], input int oddForce,
                          input int corrupt, input int idle, input int stallAt,
                          input int stallLen, input bit wantGood);
    int v0, e0;
    curReq = req;
    v0 = gotValid; e0 = gotErr;
    buildFrame(8'h01 + pay.size(), 8'h20, 8'h7f, 8'h03, 8'h40, pay, oddForce, corrupt);
    sendAll(idle, stallAt, stallLen);
    if (wantGood) begin
      check(gotValid - v0 == 1, "valid pulse count", gotValid - v0, 1);
      check(gotErr - e0 == 0, "error pulse count", gotErr - e0, 0);
      foreach (expPay[i]) begin
        rdAddr = i[4:0];
        #1;
        check(rdData == expPay[i], "payload byte R3", rdData, expPay[i]);
      end
    end else begin
      check(gotValid - v0 == 0, "valid pulse count", gotValid - v0, 0);
      check(gotErr - e0 >= 1, "error pulse count", gotErr - e0, 1);
    end
  endtask

  function automatic void mkPay(ref byte unsigned q[$], input int n, input int seed);
    q.delete();
    for (int i = 0; i < n; i++) q.push_back(8'((i * 37 + seed) ^ (i << 5)));
  endfunction

  initial begin
    byte unsigned p[$];
    repeat (3) @(negedge clk);
    curReq = "R10";
    check(pktValid == 0 && pktError == 0, "pulses in reset R10", {pktValid, pktError}, 0);
    check(hdrDest == 0 && payLen == 0, "header/len in reset R10", payLen, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pktValid == 0 && pktError == 0, "pulses after reset R10", {pktValid, pktError}, 0);

    // R1 R2 R3: command-like frame, O=2 G=1
    p = '{8'h01, 8'h03, 8'h00, 8'h18, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00};
    runFrame("R1", p, -1, 0, 2, -1, 0, 1);
    mkPay(p, 0, 3);   runFrame("R3", p, -1, 0, 1, -1, 0, 1);
    mkPay(p, 7, 9);   runFrame("R3", p, -1, 0, 0, -1, 0, 1);
    mkPay(p, 20, 11); runFrame("R2", p, -1, 0, 3, -1, 0, 1);
    mkPay(p, 32, 5);  runFrame("R7", p, -1, 0, 1, -1, 0, 1);
    mkPay(p, 33, 5);  runFrame("R7", p, -1, 0, 1, -1, 0, 0);
    mkPay(p, 5, 1);   runFrame("R7", p, 7, 0, 1, -1, 0, 0);
    mkPay(p, 9, 21);  runFrame("R4", p, -1, 1, 1, -1, 0, 0);
    mkPay(p, 9, 22);  runFrame("R5", p, -1, 2, 1, -1, 0, 0);
    mkPay(p, 9, 23);  runFrame("R6", p, -1, 3, 1, -1, 0, 0);
    // R8: byte on the expiring cycle wins, one more idle cycle aborts
    mkPay(p, 10, 30); runFrame("R8", p, -1, 0, LIM - 1, -1, 0, 1);
    mkPay(p, 10, 31); runFrame("R8", p, -1, 0, 1, 14, LIM, 0);
    mkPay(p, 14, 40); runFrame("R9", p, -1, 0, 1, -1, 0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule